// File: doc/BRIEF.md
# Jump Condition and Next-PC Unit

This unit resolves one jump instruction per clock. From the current program counter, the jump's operation code, a class bit, a source-select bit, the two operands and the instruction's offset and immediate fields, it decides whether the jump is taken. It also produces the address of the next instruction to run. Addresses count instruction slots, not bytes. All displacements are measured from the slot that follows the jump.

The unconditional jump has two reaches. In the 64-bit jump class it moves by the signed 16-bit offset field. In the 32-bit jump class it moves by the signed 32-bit immediate field. The conditional codes supported here are equality, unsigned greater-than and unsigned greater-or-equal. They always move by the 16-bit offset. Any other operation code, and an unconditional jump whose source-select bit is set, is reported as unsupported and falls through.

The results are registered. They appear one clock after the inputs are presented, so the unit can sit directly in a pipeline stage.

Top module: `bt_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs become `next_pc_o` = 0, `taken_o` = 0 and `unsupported_o` = 0.
- R2: All outputs are registered. The result for inputs sampled at one rising edge appears after that edge, and inputs changed between edges leave the outputs unchanged.
- R3: Code 0 with `cls32_i` = 0 and `src_sel_i` = 0 is taken, with `next_pc_o` = `pc_i` + 1 + sign-extended `off_i`. `imm_i` has no effect.
- R4: Code 0 with `cls32_i` = 1 and `src_sel_i` = 0 (the opcode byte 0x06 form) is taken, with `next_pc_o` = `pc_i` + 1 + sign-extended `imm_i`. `off_i` has no effect.
- R5: Code 0 with `src_sel_i` = 1 gives `unsupported_o` = 1 and `taken_o` = 0, and `next_pc_o` = `pc_i` + 1.
- R6: Code 1 is taken when the compared destination equals the compared source.
- R7: Code 2 is taken when the destination is greater than the source, compared unsigned.
- R8: Code 3 is taken when the destination is greater than or equal to the source, compared unsigned.
- R9: With `src_sel_i` = 1 the source is `src_i`. With `src_sel_i` = 0 it is `imm_i` sign-extended to 64 bits.
- R10: With `cls32_i` = 1 the conditional codes compare only bits 31:0 of both sides. With `cls32_i` = 0 they compare all 64 bits.
- R11: A taken conditional jump gives `pc_i` + 1 + sign-extended `off_i` in both classes. A jump that is not taken gives `pc_i` + 1.
- R12: Codes 4 to 15 give `unsupported_o` = 1 and `taken_o` = 0, and `next_pc_o` = `pc_i` + 1.
- R13: Next-PC arithmetic wraps modulo 2^`PC_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | PC_W | Slot address of the jump |
| code_i | input | 4 | Operation code: 0 always, 1 equal, 2 unsigned greater, 3 unsigned greater-or-equal |
| cls32_i | input | 1 | 1 selects the 32-bit jump class, 0 the 64-bit class |
| src_sel_i | input | 1 | 1 compares against `src_i`, 0 against the immediate |
| dst_i | input | 64 | Destination operand |
| src_i | input | 64 | Source register operand |
| off_i | input | 16 | Signed offset field |
| imm_i | input | 32 | Signed immediate field |
| next_pc_o | output | PC_W | Address of the next slot to execute |
| taken_o | output | 1 | Jump taken |
| unsupported_o | output | 1 | Code or encoding not handled |

## Verification
Every result of this unit is due exactly one rising edge after its inputs are sampled: `next_pc_o`, `taken_o` and `unsupported_o` all come from the same register stage. The bench drives each input set on a falling edge and compares the three outputs on the following falling edge, so exactly one rising edge lies between stimulus and check. For the latency requirement, it also inspects the outputs just after a change of inputs and before any rising edge. This proves that nothing reaches the outputs combinationally.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int unsigned OPND_W = 64;
    localparam int unsigned HALF_W = 32;
    localparam int unsigned OFF_W  = 16;
    localparam int unsigned IMM_W  = 32;
    localparam int unsigned CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        JC_ALWAYS = 4'd0,
        JC_EQ     = 4'd1,
        JC_GTU    = 4'd2,
        JC_GEU    = 4'd3
    } jcode_e;

    typedef struct packed {
        logic take;
        logic bad;
    } verdict_t;

    function automatic logic [OPND_W-1:0] widen_imm(input logic [IMM_W-1:0] v);
        return OPND_W'(signed'(v));
    endfunction

    function automatic logic code_known(input logic [CODE_W-1:0] c);
        return c <= CODE_W'(JC_GEU);
    endfunction

endpackage

// File: rtl/bt_cond_eval.sv
module bt_cond_eval
    import bt_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              cls32,
    input  logic              src_sel,
    input  logic [OPND_W-1:0] dst,
    input  logic [OPND_W-1:0] srcv,
    input  logic [IMM_W-1:0]  imm,
    output verdict_t          verdict
);
    logic [OPND_W-1:0] rhs;
    logic [OPND_W-1:0] lhs_c;
    logic [OPND_W-1:0] rhs_c;
    logic              eq;
    logic              gtu;
    logic              hit;

    always_comb begin
        rhs = src_sel ? srcv : widen_imm(imm);
        if (cls32) begin
            lhs_c = {{(OPND_W-HALF_W){1'b0}}, dst[HALF_W-1:0]};
            rhs_c = {{(OPND_W-HALF_W){1'b0}}, rhs[HALF_W-1:0]};
        end else begin
            lhs_c = dst;
            rhs_c = rhs;
        end
        eq  = (lhs_c == rhs_c);
        gtu = (lhs_c > rhs_c);
    end

    always_comb begin
        hit         = 1'b0;
        verdict.bad = 1'b0;
        unique case (code)
            CODE_W'(JC_ALWAYS): begin
                hit         = !src_sel;
                verdict.bad = src_sel;
            end
            CODE_W'(JC_EQ):  hit = eq;
            CODE_W'(JC_GTU): hit = gtu;
            CODE_W'(JC_GEU): hit = gtu | eq;
            default:         verdict.bad = 1'b1;
        endcase
        verdict.take = hit & ~verdict.bad;
    end

    // R12: an unknown code can never be reported as taken
    always_comb begin
        if (!code_known(code))
            a_r12_unknown_not_taken: assert (!verdict.take);
    end

endmodule

// File: rtl/bt_target_calc.sv
module bt_target_calc
    import bt_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic [PC_W-1:0]  pc,
    input  logic             use_imm,
    input  logic [OFF_W-1:0] off,
    input  logic [IMM_W-1:0] imm,
    output logic [PC_W-1:0]  target,
    output logic [PC_W-1:0]  fallthru
);
    localparam int unsigned EXT_W = (PC_W > IMM_W) ? PC_W : IMM_W;

    logic [EXT_W-1:0] off_x;
    logic [EXT_W-1:0] imm_x;
    logic [PC_W-1:0]  disp;

    always_comb begin
        off_x    = EXT_W'(signed'(off));
        imm_x    = EXT_W'(signed'(imm));
        disp     = use_imm ? imm_x[PC_W-1:0] : off_x[PC_W-1:0];
        fallthru = pc + PC_W'(1);
        target   = fallthru + disp;
    end

endmodule

// File: rtl/bt_unit.sv
module bt_unit
    import bt_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [3:0]        code_i,
    input  logic              cls32_i,
    input  logic              src_sel_i,
    input  logic [63:0]       dst_i,
    input  logic [63:0]       src_i,
    input  logic [15:0]       off_i,
    input  logic [31:0]       imm_i,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              taken_o,
    output logic              unsupported_o
);
    verdict_t        verdict;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] fallthru;
    logic            far_form;

    assign far_form = (code_i == CODE_W'(JC_ALWAYS)) & cls32_i;

    bt_cond_eval u_cond (
        .code    (code_i),
        .cls32   (cls32_i),
        .src_sel (src_sel_i),
        .dst     (dst_i),
        .srcv    (src_i),
        .imm     (imm_i),
        .verdict (verdict)
    );

    bt_target_calc #(.PC_W(PC_W)) u_tgt (
        .pc       (pc_i),
        .use_imm  (far_form),
        .off      (off_i),
        .imm      (imm_i),
        .target   (target),
        .fallthru (fallthru)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc_o     <= '0;
            taken_o       <= 1'b0;
            unsupported_o <= 1'b0;
        end else begin
            next_pc_o     <= verdict.take ? target : fallthru;
            taken_o       <= verdict.take;
            unsupported_o <= verdict.bad;
        end
    end

    // R5 / R12: the flags are exclusive
    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(taken_o && unsupported_o));

    // R11: a fall-through lands on the next slot
    a_r11_fallthru_next: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (taken_o || next_pc_o == $past(pc_i) + PC_W'(1)));

    // R5: an unconditional jump with the register source bit is rejected
    a_r5_ja_src_rejected: assert property (@(posedge clk) disable iff (rst)
        (code_i == 4'd0 && src_sel_i) |=> (unsupported_o && !taken_o));

    // R12: codes above 3 are rejected
    a_r12_code_rejected: assert property (@(posedge clk) disable iff (rst)
        (code_i > 4'd3) |=> (unsupported_o && !taken_o));

    // R3 / R4: the plain unconditional jump is always taken
    a_r3_ja_taken: assert property (@(posedge clk) disable iff (rst)
        (code_i == 4'd0 && !src_sel_i) |=> (taken_o && !unsupported_o));

    // R8: greater-or-equal on equal register operands is taken
    a_r8_geu_equal: assert property (@(posedge clk) disable iff (rst)
        (code_i == 4'd3 && src_sel_i && dst_i == src_i) |=> taken_o);

endmodule

// File: tb/bt_unit_tb.sv
module bt_unit_tb;
    localparam int PC_W = 32;

    typedef struct packed {
        logic [31:0] pc;
        logic [3:0]  code;
        logic        cls;
        logic        src;
        logic [63:0] dst;
        logic [63:0] sv;
        logic [15:0] off;
        logic [31:0] imm;
        logic [31:0] epc;
        logic        etk;
        logic        eun;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R3 forward, imm ignored
        '{32'd100, 4'd0, 1'b0, 1'b0, 64'd0, 64'd0, 16'd5, 32'h1000, 32'd106, 1'b1, 1'b0},
        // R3 backward
        '{32'd100, 4'd0, 1'b0, 1'b0, 64'd0, 64'd0, 16'hFFFD, 32'd0, 32'd98, 1'b1, 1'b0},
        // R4 wide reach, off ignored
        '{32'd100, 4'd0, 1'b1, 1'b0, 64'd0, 64'd0, 16'd7, 32'h0001_0000, 32'h0001_0065, 1'b1, 1'b0},
        // R4 backward
        '{32'd100, 4'd0, 1'b1, 1'b0, 64'd0, 64'd0, 16'd0, 32'hFFFF_FFFE, 32'd99, 1'b1, 1'b0},
        // R5
        '{32'd100, 4'd0, 1'b0, 1'b1, 64'd0, 64'd0, 16'd5, 32'd9, 32'd101, 1'b0, 1'b1},
        // R6 equal
        '{32'd100, 4'd1, 1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 16'd10, 32'd0, 32'd111, 1'b1, 1'b0},
        // R6 / R10 differ in bit 40, 64-bit class
        '{32'd100, 4'd1, 1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5778_9ABC_DEF0, 16'd10, 32'd0, 32'd101, 1'b0, 1'b0},
        // R10 same, 32-bit class
        '{32'd100, 4'd1, 1'b1, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5778_9ABC_DEF0, 16'd10, 32'd0, 32'd111, 1'b1, 1'b0},
        // R7 unsigned greater
        '{32'd100, 4'd2, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'd20, 32'd0, 32'd121, 1'b1, 1'b0},
        // R7 equal not greater
        '{32'd100, 4'd2, 1'b0, 1'b1, 64'd5, 64'd5, 16'd20, 32'd0, 32'd101, 1'b0, 1'b0},
        // R8 equal
        '{32'd100, 4'd3, 1'b0, 1'b1, 64'd5, 64'd5, 16'hFFFF, 32'd0, 32'd100, 1'b1, 1'b0},
        // R8 less
        '{32'd100, 4'd3, 1'b0, 1'b1, 64'd4, 64'd5, 16'd9, 32'd0, 32'd101, 1'b0, 1'b0},
        // R9 immediate sign-extended
        '{32'd100, 4'd3, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'd2, 32'hFFFF_FFFF, 32'd103, 1'b1, 1'b0},
        // R9 sign extension makes rhs large
        '{32'd100, 4'd2, 1'b0, 1'b0, 64'h0000_0000_8000_0001, 64'd0, 16'd2, 32'h8000_0000, 32'd101, 1'b0, 1'b0},
        // R11 32-bit conditional uses offset
        '{32'd100, 4'd1, 1'b1, 1'b1, 64'd7, 64'd7, 16'd3, 32'h100, 32'd104, 1'b1, 1'b0},
        // R12
        '{32'd100, 4'd5, 1'b0, 1'b1, 64'd1, 64'd1, 16'd3, 32'd0, 32'd101, 1'b0, 1'b1},
        // R12
        '{32'd100, 4'd15, 1'b1, 1'b0, 64'd1, 64'd1, 16'd3, 32'd0, 32'd101, 1'b0, 1'b1},
        // R13 wrap up
        '{32'hFFFF_FFFF, 4'd0, 1'b0, 1'b0, 64'd0, 64'd0, 16'd0, 32'd0, 32'd0, 1'b1, 1'b0},
        // R13 wrap down
        '{32'd0, 4'd0, 1'b0, 1'b0, 64'd0, 64'd0, 16'hFFFE, 32'd0, 32'hFFFF_FFFF, 1'b1, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst;
    logic [PC_W-1:0] pc_i;
    logic [3:0]      code_i;
    logic            cls32_i;
    logic            src_sel_i;
    logic [63:0]     dst_i;
    logic [63:0]     src_i;
    logic [15:0]     off_i;
    logic [31:0]     imm_i;
    logic [PC_W-1:0] next_pc_o;
    logic            taken_o;
    logic            unsupported_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bt_unit #(.PC_W(PC_W)) u_dut (
        .clk(clk), .rst(rst), .pc_i(pc_i), .code_i(code_i), .cls32_i(cls32_i),
        .src_sel_i(src_sel_i), .dst_i(dst_i), .src_i(src_i), .off_i(off_i),
        .imm_i(imm_i), .next_pc_o(next_pc_o), .taken_o(taken_o),
        .unsupported_o(unsupported_o)
    );

    task automatic drive(input vec_t v);
        pc_i = v.pc; code_i = v.code; cls32_i = v.cls; src_sel_i = v.src;
        dst_i = v.dst; src_i = v.sv; off_i = v.off; imm_i = v.imm;
    endtask

    task automatic check(input string req, input logic [31:0] epc,
                         input logic etk, input logic eun);
        checks++;
        if (next_pc_o !== epc || taken_o !== etk || unsupported_o !== eun) begin
            errors++;
            $display("FAIL %s: got pc=%h tk=%b un=%b, expected pc=%h tk=%b un=%b",
                     req, next_pc_o, taken_o, unsupported_o, epc, etk, eun);
        end
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        check("R1 reset", 32'd0, 1'b0, 1'b0);
        rst = 1'b0;

        // R2: a new input set is not visible before the next rising edge
        drive(VECS[2]);
        #1;
        check("R2 before edge", 32'd0, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 after edge", 32'h0001_0065, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("vector %0d (R3..R13)", i), VECS[i].epc, VECS[i].etk, VECS[i].eun);
        end

        // R2: inputs changed mid-cycle leave the outputs unchanged
        drive(VECS[4]);
        #1;
        check("R2 hold", 32'hFFFF_FFFF, 1'b1, 1'b0);

        // R1: reset during a taken jump clears everything
        drive(VECS[0]);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", 32'd0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R3 after reset", 32'd106, 1'b1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule